// File: doc/BRIEF.md
# Successive-Approximation Oscillator Start-Point Sequencer

This block sets the starting point of a digitally controlled oscillator after a request to relock. On a start trigger it enters search mode, in which its own trial word drives the oscillator in place of the loop-filter output. It first settles a 2-bit delay-select code for the reference-delay line, then a 10-bit oscillator control word, one bit per reference period in both searches. Every trial fits inside one reference period. The oscillator and its divider are held off while the reference is high. They run while it is low, and the phase detectors report at the next rising reference edge whether the divider edge came early.

When the last word bit is settled, the block emits a one-cycle load pulse so the loop filter takes the word as its integral starting value, and search mode ends. The delay code and the word then stay fixed. A configuration input picks whether the delayed or the plain reference feeds the loop after the search.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, search_o and load_o are 0, dco_en_o is 1, div_rst_o is 0 and both dly_sel_o and dco_word_o are 0.
- R2: The cycle after start_i is sampled high, search_o is 1, dly_sel_o is 2'b10, dco_word_o is 10'h200 (MSB only) and the oscillator is held off.
- R3: In search mode, dco_en_o is 1 and div_rst_o is 0 only from the cycle after a sampled falling reference edge until the cycle after the next sampled rising edge. Otherwise dco_en_o is 0 and div_rst_o is 1.
- R4: The delay search comes first and settles dly_sel_o MSB first. At each rising reference edge that ends a trial, the trial bit is cleared if fall_early_i is 1 (divider falling edge before the delayed reference), otherwise it is kept, and the next lower bit is set.
- R5: The word search then settles dco_word_o MSB first over 10 trials, using the same keep or clear rule driven by rise_early_i (1 means the divider rising edge came before the reference, so the oscillator is too fast).
- R6: The cycle after the LSB decision, load_o is 1 for exactly one cycle and search_o falls in that same cycle.
- R7: dly_sel_o does not change during the word search. Outside search mode, neither output code changes until the next start.
- R8: ref_sel_o is 1 during search mode and follows use_dly_i outside it.
- R9: A start during a search discards it and restarts from the delay MSB.
- R10: A rising reference edge with no trial released since the start (no falling edge seen yet) makes no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Relock trigger, one cycle |
| use_dly_i | input | 1 | After search: 1 selects the delayed reference for the loop |
| ref_lvl_i | input | 1 | Sampled reference level |
| fall_early_i | input | 1 | Divider falling edge came before the delayed reference |
| rise_early_i | input | 1 | Divider rising edge came before the reference |
| dly_sel_o | output | 2 | Delay-line select code |
| dco_word_o | output | 10 | Trial / final oscillator control word |
| dco_en_o | output | 1 | Oscillator enable |
| div_rst_o | output | 1 | Divider reset |
| search_o | output | 1 | Search mode; oscillator driven by this block |
| ref_sel_o | output | 1 | Reference select for the loop (1 = delayed) |
| load_o | output | 1 | One-cycle hand-over of the final word |

## Verification
A wrong bit pointer or a wrong decision shows at the ports within one reference period. The trial bit pattern of dly_sel_o or dco_word_o then differs from the model at the rising edge that should have made the decision. A trial flag out of step shows at once on dco_en_o and div_rst_o, at the cycle after a reference edge. A wrong phase step moves the load pulse and the fall of search_o off the twelfth decision. The emulated oscillator answers from a fixed target, so the final word must equal that target exactly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DLY  = 2'd1,
    PH_FRQ  = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_seq_edge.sv
module sar_seq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/sar_seq_bits.sv
module sar_seq_bits #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         step_i,
  input  logic         early_i,
  output logic [W-1:0] code_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q, code_n;
  logic [W-1:0] ptr_q, ptr_n;

  // next state: one-hot pointer walks toward the LSB
  always_comb begin
    code_n = code_q;
    ptr_n  = ptr_q;
    if (init_i) begin
      code_n = TOP_BIT;
      ptr_n  = TOP_BIT;
    end else if (step_i) begin
      code_n = code_q & ~(early_i ? ptr_q : '0);
      ptr_n  = ptr_q >> 1;
      code_n = code_n | (ptr_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ptr_q  <= '0;
    end else if (init_i || step_i) begin
      code_q <= code_n;
      ptr_q  <= ptr_n;
    end
  end

  assign code_o = code_q;
  assign last_o = ptr_q[0];
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int DLY_W = 2,
  parameter int FRQ_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             use_dly_i,
  input  logic             ref_lvl_i,
  input  logic             fall_early_i,
  input  logic             rise_early_i,
  output logic [DLY_W-1:0] dly_sel_o,
  output logic [FRQ_W-1:0] dco_word_o,
  output logic             dco_en_o,
  output logic             div_rst_o,
  output logic             search_o,
  output logic             ref_sel_o,
  output logic             load_o
);
  import sar_seq_pkg::*;

  phase_t phase_q, phase_n;
  logic   trial_q, trial_n;
  logic   load_q, load_n;
  logic   ref_rise, ref_fall;
  logic   dly_step, frq_step, dly_last, frq_last;
  logic   decide;

  sar_seq_edge edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(ref_lvl_i),
    .rise_o(ref_rise), .fall_o(ref_fall)
  );

  // a decision needs a released trial that the rising edge now ends
  assign decide   = ref_rise & trial_q & ~start_i;
  assign dly_step = decide & (phase_q == PH_DLY);
  assign frq_step = decide & (phase_q == PH_FRQ);

  sar_seq_bits #(.W(DLY_W)) dly_bits_i (
    .clk(clk), .rst_n(rst_n), .init_i(start_i), .step_i(dly_step),
    .early_i(fall_early_i), .code_o(dly_sel_o), .last_o(dly_last)
  );

  sar_seq_bits #(.W(FRQ_W)) frq_bits_i (
    .clk(clk), .rst_n(rst_n), .init_i(start_i), .step_i(frq_step),
    .early_i(rise_early_i), .code_o(dco_word_o), .last_o(frq_last)
  );

  always_comb begin
    phase_n = phase_q;
    trial_n = trial_q;
    load_n  = 1'b0;
    if (start_i) begin
      phase_n = PH_DLY;
      trial_n = 1'b0;
    end else begin
      if (ref_rise)                          trial_n = 1'b0;
      else if (ref_fall && phase_q != PH_IDLE) trial_n = 1'b1;
      if (dly_step && dly_last) phase_n = PH_FRQ;
      if (frq_step && frq_last) begin
        phase_n = PH_IDLE;
        load_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      trial_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      trial_q <= trial_n;
      load_q  <= load_n;
    end
  end

  assign search_o  = (phase_q != PH_IDLE);
  assign dco_en_o  = ~search_o | trial_q;
  assign div_rst_o = ~dco_en_o;
  assign ref_sel_o = search_o | use_dly_i;
  assign load_o    = load_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DLY_W = 2,
  parameter int FRQ_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ref_lvl_i,
  input logic [DLY_W-1:0] dly_sel_o,
  input logic [FRQ_W-1:0] dco_word_o,
  input logic             dco_en_o,
  input logic             div_rst_o,
  input logic             search_o,
  input logic             load_o
);
  localparam logic [DLY_W-1:0] D_TOP = {1'b1, {(DLY_W-1){1'b0}}};
  localparam logic [FRQ_W-1:0] F_TOP = {1'b1, {(FRQ_W-1){1'b0}}};

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (search_o && dly_sel_o == D_TOP && dco_word_o == F_TOP && !dco_en_o));

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_o && $past(search_o) && ref_lvl_i && $past(ref_lvl_i)) |-> (!dco_en_o && div_rst_o));

  // R6
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R6
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(search_o) |-> load_o);

  // R7
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_o && !$past(start_i) && dco_word_o != $past(dco_word_o)) |-> $stable(dly_sel_o));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!search_o && !$past(search_o) && !$past(start_i)) |-> ($stable(dly_sel_o) && $stable(dco_word_o)));
endmodule

bind sar_seq_top sar_seq_chk #(.DLY_W(DLY_W), .FRQ_W(FRQ_W)) chk_i (.*);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       use_dly_i = 1'b0;
  logic       ref_lvl_i = 1'b0;
  logic       fall_early_i = 1'b0;
  logic       rise_early_i = 1'b0;
  logic [1:0] dly_sel_o;
  logic [9:0] dco_word_o;
  logic       dco_en_o, div_rst_o, search_o, ref_sel_o, load_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cnt = 0;
  int per = 16;
  int tgt_dly = 0;
  int tgt_frq = 0;
  int nload = 0;
  bit done_flag = 0;

  // model state
  bit m_refq, m_trial, m_load;
  int m_phase, m_bit, m_dly, m_frq;

  always #4 clk = ~clk;

  sar_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .use_dly_i(use_dly_i),
    .ref_lvl_i(ref_lvl_i), .fall_early_i(fall_early_i), .rise_early_i(rise_early_i),
    .dly_sel_o(dly_sel_o), .dco_word_o(dco_word_o), .dco_en_o(dco_en_o),
    .div_rst_o(div_rst_o), .search_o(search_o), .ref_sel_o(ref_sel_o), .load_o(load_o)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_refq = 0; m_trial = 0; m_load = 0;
      m_phase = 0; m_bit = 0; m_dly = 0; m_frq = 0;
    end else begin
      bit rise, fall;
      rise = ref_lvl_i && !m_refq;
      fall = !ref_lvl_i && m_refq;
      m_load = 0;
      if (start_i) begin
        m_phase = 1; m_bit = 1; m_dly = 2; m_frq = 512; m_trial = 0;
      end else begin
        bit dec;
        dec = rise && m_trial;
        if (rise) m_trial = 0;
        else if (fall && m_phase != 0) m_trial = 1;
        if (dec && m_phase == 1) begin
          if (fall_early_i) m_dly = m_dly & ~(1 << m_bit);
          if (m_bit == 0) begin m_phase = 2; m_bit = 9; end
          else begin m_bit = m_bit - 1; m_dly = m_dly | (1 << m_bit); end
        end else if (dec && m_phase == 2) begin
          if (rise_early_i) m_frq = m_frq & ~(1 << m_bit);
          if (m_bit == 0) begin m_phase = 0; m_load = 1; end
          else begin m_bit = m_bit - 1; m_frq = m_frq | (1 << m_bit); end
        end
      end
      m_refq = ref_lvl_i;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic compare();
    bit srch;
    srch = (m_phase != 0);
    check("R4 dly_sel", int'(dly_sel_o), m_dly);
    check("R5 dco_word", int'(dco_word_o), m_frq);
    check("R3 dco_en", int'(dco_en_o), int'(!srch || m_trial));
    check("R3 div_rst", int'(div_rst_o), int'(srch && !m_trial));
    check("R2 search", int'(search_o), int'(srch));
    check("R6 load", int'(load_o), int'(m_load));
    check("R8 ref_sel", int'(ref_sel_o), int'(srch || use_dly_i));
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    compare();
    if (load_o) nload++;
    cnt++;
    ref_lvl_i = ((cnt % per) < (per / 2));
    fall_early_i = (int'(dly_sel_o) > tgt_dly);
    rise_early_i = (int'(dco_word_o) > tgt_frq);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic run_search(input string tag);
    int guard;
    guard = 0;
    nload = 0;
    while (search_o && guard < 2000) begin
      tick();
      guard++;
    end
    check({tag, " R4 final delay"}, int'(dly_sel_o), tgt_dly);
    check({tag, " R5 final word"}, int'(dco_word_o), tgt_frq);
    check({tag, " R6 load count"}, nload, 1);
  endtask

  task automatic settle_idle(input string tag);
    logic [1:0] d0;
    logic [9:0] w0;
    d0 = dly_sel_o;
    w0 = dco_word_o;
    for (int i = 0; i < 40; i++) tick();
    check({tag, " R7 delay held"}, int'(dly_sel_o), int'(d0));
    check({tag, " R7 word held"}, int'(dco_word_o), int'(w0));
    check({tag, " R8 ref_sel idle"}, int'(ref_sel_o), int'(use_dly_i));
    check({tag, " R3 dco_en idle"}, int'(dco_en_o), 1);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 search", int'(search_o), 0);
    check("R1 load", int'(load_o), 0);
    check("R1 dco_en", int'(dco_en_o), 1);
    check("R1 div_rst", int'(div_rst_o), 0);
    check("R1 dly_sel", int'(dly_sel_o), 0);
    check("R1 dco_word", int'(dco_word_o), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();

    // basic search, mid-range target
    tgt_dly = 3; tgt_frq = 'h2A5; use_dly_i = 0;
    pulse_start();
    check("R2 search after start", int'(search_o), 1);
    check("R2 word MSB", int'(dco_word_o), 'h200);
    check("R2 delay MSB", int'(dly_sel_o), 2);
    run_search("A");
    settle_idle("A");

    // extreme low, other period and cfg
    per = 10; tgt_dly = 0; tgt_frq = 0; use_dly_i = 1;
    pulse_start();
    run_search("B");
    settle_idle("B");

    // extreme high
    per = 16; tgt_dly = 1; tgt_frq = 'h3FF; use_dly_i = 0;
    for (int i = 0; i < 3; i++) tick();
    pulse_start();
    run_search("C");
    settle_idle("C");

    // R9: restart during word search
    tgt_dly = 2; tgt_frq = 'h155;
    pulse_start();
    for (int i = 0; i < 70; i++) tick();
    check("R9 mid-search", int'(search_o), 1);
    tgt_dly = 1; tgt_frq = 'h0AA;
    pulse_start();
    check("R9 restart delay MSB", int'(dly_sel_o), 2);
    check("R9 restart word MSB", int'(dco_word_o), 'h200);
    run_search("R9");
    settle_idle("R9");

    // R10: start while reference low, first rising edge decides nothing
    tgt_dly = 0; tgt_frq = 'h001;
    while (!(ref_lvl_i == 1'b0 && ((cnt % per) == per / 2 + 1))) tick();
    pulse_start();
    while (ref_lvl_i == 1'b0) tick();
    tick(); tick();
    check("R10 no decision on first rise", int'(dly_sel_o), 2);
    check("R10 held off", int'(dco_en_o), 0);
    run_search("R10");
    settle_idle("R10");

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule